// File: doc/BRIEF.md
# Serial Converter Host Controller

This block is the system-side master for a three-wire serial analog-to-digital converter. The converter has a conversion-start line, a serial clock and a serial data return. The controller takes one command at a time from the system and drives both control lines. It derives the serial clock from the system clock by a parameterized divider. After each conversion it shifts in the returned frame and hands back a 12-bit result, together with the converter's reference-ready flag.

The same two wires also carry power-mode requests. A nap request is two start pulses with the serial clock held low. A sleep request is four such pulses. Wake is a single serial clock pulse. After a sleep, the reference needs time to settle, so the controller raises a not-ready flag. The flag stays up until a frame returns its leading ready bit as 1.

All timing is counted in system clock cycles and set by parameters: the half period of the serial clock, the start-pulse width, the lead from start to the first clock edge, the recovery gap after a frame, the guard after a power request and the wake settling time.

Top module: `sar_link_host`

## Requirements
- R1: A command is taken only while `busy` is low. The command codes are convert=0, nap=1, sleep=2 and wake=3. `busy` rises on the cycle after acceptance and stays high until the sequence ends. A command presented while `busy` is high has no effect.
- R2: A convert command drives `adcConv` high for exactly CONV_HI cycles with `adcSclk` low. The first rising edge of `adcSclk` follows the falling edge of `adcConv` by LEAD_CYCLES + DIV_HALF cycles.
- R3: A conversion frame has exactly 16 rising edges of `adcSclk`. Each high phase lasts DIV_HALF cycles, and consecutive rising edges are 2*DIV_HALF cycles apart.
- R4: `adcSdout` is sampled when `adcSclk` rises. The sample taken at rising edge 2 is the ready bit. Edges 3 to 14 give the data, most significant bit first. The samples at edges 1, 15 and 16 are discarded.
- R5: At the end of a frame, `resultValid` is high for exactly one cycle, with `resultData` and `resultReady` valid in that cycle. `busy` falls GAP_CYCLES cycles after the pulse cycle.
- R6: A nap command produces two `adcConv` pulses, each CONV_HI cycles high and CONV_HI cycles low, with `adcSclk` low throughout. `busy` then stays high for a further REQ_GAP cycles.
- R7: A sleep command produces four such pulses, followed by the same REQ_GAP guard. It sets `notReady`.
- R8: A wake command produces one `adcSclk` pulse DIV_HALF cycles high and no `adcConv` pulse. `busy` then stays high for WAKE_WAIT more cycles.
- R9: `notReady` is set by a frame whose ready bit is 0 and by a sleep command. It is cleared only by a frame whose ready bit is 1.
- R10: During and after reset, `adcConv`, `adcSclk`, `busy`, `resultValid` and `notReady` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command request |
| cmdOp | input | 2 | Command code (0 convert, 1 nap, 2 sleep, 3 wake) |
| busy | output | 1 | Sequence in progress |
| adcConv | output | 1 | Conversion-start / power-request line to the converter |
| adcSclk | output | 1 | Serial clock to the converter |
| adcSdout | input | 1 | Serial data from the converter |
| resultValid | output | 1 | One-cycle result strobe |
| resultData | output | 12 | Conversion result |
| resultReady | output | 1 | Ready bit of the latest frame |
| notReady | output | 1 | Reference not yet confirmed ready |

## Verification
The bench builds the controller with a serial half period of 3 cycles, a 2-cycle start pulse, a 4-cycle lead, a 5-cycle recovery gap, a 3-cycle request guard and a 6-cycle wake wait. With these values a full conversion takes about a hundred cycles, so every command sequence can have its duration counted exactly. The short values also keep the start width, lead, clock phase and gap distinct from one another. An error in any one of them therefore changes a measured count.

// File: rtl/sar_link_pkg.sv
package sar_link_pkg;

  typedef enum logic [1:0] {
    CMD_CONVERT = 2'd0,
    CMD_NAP     = 2'd1,
    CMD_SLEEP   = 2'd2,
    CMD_WAKE    = 2'd3
  } cmd_e;

  // strobes from control to datapath
  typedef struct packed {
    logic convHigh;   // start line should be high
    logic sclkHigh;   // serial clock should be high
    logic capture;    // sample the data line as the clock rises
    logic frameDone;  // publish the assembled word
    logic sleepEntry; // a sleep request was accepted
  } strobe_t;

  function automatic int maxInt(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sar_link_ctrl.sv
module sar_link_ctrl
  import sar_link_pkg::*;
#(
  parameter int DIV_HALF    = 16,
  parameter int CONV_HI     = 4,
  parameter int LEAD_CYCLES = 10,
  parameter int GAP_CYCLES  = 36,
  parameter int REQ_GAP     = 5,
  parameter int WAKE_WAIT   = 35,
  parameter int FRAME_EDGES = 16,
  parameter int READY_EDGE  = 2,
  parameter int DATA_W      = 12
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [1:0] cmdOp,
  output logic       busy,
  output strobe_t    strobe
);

  localparam int TMAX = maxInt(maxInt(maxInt(DIV_HALF, CONV_HI), maxInt(LEAD_CYCLES, GAP_CYCLES)),
                               maxInt(REQ_GAP, WAKE_WAIT));
  localparam int TW  = $clog2(TMAX + 1);
  localparam int ECW = $clog2(FRAME_EDGES + 1);

  localparam logic [TW-1:0]  T_HALF  = TW'(DIV_HALF - 1);
  localparam logic [TW-1:0]  T_CONV  = TW'(CONV_HI - 1);
  localparam logic [TW-1:0]  T_LEAD  = TW'(LEAD_CYCLES - 1);
  localparam logic [TW-1:0]  T_GAP   = TW'(GAP_CYCLES - 1);
  localparam logic [TW-1:0]  T_GUARD = TW'(REQ_GAP - 1);
  localparam logic [TW-1:0]  T_WAKE  = TW'(WAKE_WAIT - 1);
  localparam logic [ECW-1:0] E_LAST  = ECW'(FRAME_EDGES);
  localparam logic [ECW-1:0] E_FIRST = ECW'(READY_EDGE);
  localparam logic [ECW-1:0] E_STOP  = ECW'(READY_EDGE + DATA_W);

  typedef enum logic [2:0] {
    ST_IDLE, ST_CONVH, ST_LEAD, ST_SHIFT, ST_PULSEH, ST_PULSEL, ST_WAKEH, ST_WAIT
  } state_e;

  state_e         state;
  logic [TW-1:0]  tmr;
  logic           phase;
  logic [ECW-1:0] edgeCnt;
  logic [2:0]     pulsesLeft;
  logic           tmrZero;

  assign tmrZero = (tmr == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      tmr        <= '0;
      phase      <= 1'b0;
      edgeCnt    <= '0;
      pulsesLeft <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (cmdValid) begin
          unique case (cmd_e'(cmdOp))
            CMD_CONVERT: begin state <= ST_CONVH;  tmr <= T_CONV; end
            CMD_NAP:     begin state <= ST_PULSEH; tmr <= T_CONV; pulsesLeft <= 3'd2; end
            CMD_SLEEP:   begin state <= ST_PULSEH; tmr <= T_CONV; pulsesLeft <= 3'd4; end
            CMD_WAKE:    begin state <= ST_WAKEH;  tmr <= T_HALF; end
          endcase
        end
        ST_CONVH:
          if (tmrZero) begin state <= ST_LEAD; tmr <= T_LEAD; end
          else tmr <= tmr - 1'b1;
        ST_LEAD:
          if (tmrZero) begin
            state   <= ST_SHIFT;
            tmr     <= T_HALF;
            phase   <= 1'b0;
            edgeCnt <= '0;
          end else tmr <= tmr - 1'b1;
        ST_SHIFT:
          if (!tmrZero) tmr <= tmr - 1'b1;
          else if (!phase) begin
            phase   <= 1'b1;
            tmr     <= T_HALF;
            edgeCnt <= edgeCnt + 1'b1;
          end else if (edgeCnt == E_LAST) begin
            state <= ST_WAIT;
            tmr   <= T_GAP;
            phase <= 1'b0;
          end else begin
            phase <= 1'b0;
            tmr   <= T_HALF;
          end
        ST_PULSEH:
          if (tmrZero) begin state <= ST_PULSEL; tmr <= T_CONV; end
          else tmr <= tmr - 1'b1;
        ST_PULSEL:
          if (!tmrZero) tmr <= tmr - 1'b1;
          else if (pulsesLeft == 3'd1) begin
            state <= ST_WAIT;
            tmr   <= T_GUARD;
          end else begin
            state      <= ST_PULSEH;
            tmr        <= T_CONV;
            pulsesLeft <= pulsesLeft - 1'b1;
          end
        ST_WAKEH:
          if (tmrZero) begin state <= ST_WAIT; tmr <= T_WAKE; end
          else tmr <= tmr - 1'b1;
        ST_WAIT:
          if (tmrZero) state <= ST_IDLE;
          else tmr <= tmr - 1'b1;
        default: state <= ST_IDLE;
      endcase
    end
  end

  logic highPhase;
  assign highPhase = (state == ST_SHIFT) && phase;

  always_comb begin
    busy              = (state != ST_IDLE);
    strobe.convHigh   = (state == ST_CONVH) || (state == ST_PULSEH);
    strobe.sclkHigh   = highPhase || (state == ST_WAKEH);
    strobe.capture    = highPhase && (tmr == T_HALF) &&
                        (edgeCnt >= E_FIRST) && (edgeCnt <= E_STOP);
    strobe.frameDone  = highPhase && tmrZero && (edgeCnt == E_LAST);
    strobe.sleepEntry = (state == ST_IDLE) && cmdValid && (cmd_e'(cmdOp) == CMD_SLEEP);
  end

endmodule

// File: rtl/sar_link_dp.sv
module sar_link_dp
  import sar_link_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic              adcSdout,
  output logic              adcConv,
  output logic              adcSclk,
  output logic              resultValid,
  output logic [DATA_W-1:0] resultData,
  output logic              resultReady,
  output logic              notReady
);

  // ready bit lands in the top position, data below it
  logic [DATA_W:0] shiftReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      adcConv     <= 1'b0;
      adcSclk     <= 1'b0;
      shiftReg    <= '0;
      resultValid <= 1'b0;
      resultData  <= '0;
      resultReady <= 1'b0;
      notReady    <= 1'b0;
    end else begin
      adcConv     <= strobe.convHigh;
      adcSclk     <= strobe.sclkHigh;
      resultValid <= strobe.frameDone;
      if (strobe.capture) shiftReg <= {shiftReg[DATA_W-1:0], adcSdout};
      if (strobe.frameDone) begin
        resultData  <= shiftReg[DATA_W-1:0];
        resultReady <= shiftReg[DATA_W];
        notReady    <= ~shiftReg[DATA_W];
      end else if (strobe.sleepEntry) begin
        notReady <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/sar_link_host.sv
module sar_link_host
  import sar_link_pkg::*;
#(
  parameter int DIV_HALF    = 16,
  parameter int CONV_HI     = 4,
  parameter int LEAD_CYCLES = 10,
  parameter int GAP_CYCLES  = 36,
  parameter int REQ_GAP     = 5,
  parameter int WAKE_WAIT   = 35,
  parameter int FRAME_EDGES = 16,
  parameter int READY_EDGE  = 2,
  parameter int DATA_W      = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  output logic              busy,
  output logic              adcConv,
  output logic              adcSclk,
  input  logic              adcSdout,
  output logic              resultValid,
  output logic [DATA_W-1:0] resultData,
  output logic              resultReady,
  output logic              notReady
);

  strobe_t strobe;

  sar_link_ctrl #(
    .DIV_HALF(DIV_HALF), .CONV_HI(CONV_HI), .LEAD_CYCLES(LEAD_CYCLES),
    .GAP_CYCLES(GAP_CYCLES), .REQ_GAP(REQ_GAP), .WAKE_WAIT(WAKE_WAIT),
    .FRAME_EDGES(FRAME_EDGES), .READY_EDGE(READY_EDGE), .DATA_W(DATA_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .busy(busy), .strobe(strobe)
  );

  sar_link_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .adcSdout(adcSdout),
    .adcConv(adcConv), .adcSclk(adcSclk), .resultValid(resultValid),
    .resultData(resultData), .resultReady(resultReady), .notReady(notReady)
  );

endmodule

// File: rtl/sar_link_host_chk.sv
module sar_link_host_chk #(
  parameter int DIV_HALF = 16,
  parameter int CONV_HI  = 4
) (
  input logic clk,
  input logic rstN,
  input logic adcConv,
  input logic adcSclk,
  input logic resultValid,
  input logic busy
);

  localparam logic [15:0] W_HALF = 16'(DIV_HALF);
  localparam logic [15:0] W_CONV = 16'(CONV_HI);

  logic [15:0] hiRun;
  logic [15:0] convRun;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiRun   <= '0;
      convRun <= '0;
    end else begin
      hiRun   <= adcSclk ? hiRun + 1'b1 : '0;
      convRun <= adcConv ? convRun + 1'b1 : '0;
    end
  end

  AST_NO_CLASH: assert property (@(posedge clk) disable iff (!rstN)
    !(adcConv && adcSclk)); // R6

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid); // R5

  AST_VALID_IN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> busy); // R5

  AST_SCLK_HIGH_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(adcSclk) |-> (hiRun == W_HALF)); // R3

  AST_CONV_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(adcConv) |-> (convRun == W_CONV)); // R2

endmodule

bind sar_link_host sar_link_host_chk #(.DIV_HALF(DIV_HALF), .CONV_HI(CONV_HI)) u_chk (
  .clk(clk), .rstN(rstN), .adcConv(adcConv), .adcSclk(adcSclk),
  .resultValid(resultValid), .busy(busy)
);

// File: tb/sar_link_host_bench.sv
module sar_link_host_bench;

  localparam int DIV_HALF = 3;
  localparam int CONV_HI  = 2;
  localparam int LEAD     = 4;
  localparam int GAP      = 5;
  localparam int GUARD    = 3;
  localparam int WAKEW    = 6;
  localparam int CONV_BUSY = CONV_HI + LEAD + 32 * DIV_HALF + GAP;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic [1:0] cmdOp = 2'd0;
  logic busy, adcConv, adcSclk, resultValid, resultReady, notReady;
  logic adcSdout = 1'b0;
  logic [11:0] resultData;

  always #2 clk = ~clk;

  sar_link_host #(
    .DIV_HALF(DIV_HALF), .CONV_HI(CONV_HI), .LEAD_CYCLES(LEAD),
    .GAP_CYCLES(GAP), .REQ_GAP(GUARD), .WAKE_WAIT(WAKEW)
  ) u_sar_link_host (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .busy(busy),
    .adcConv(adcConv), .adcSclk(adcSclk), .adcSdout(adcSdout),
    .resultValid(resultValid), .resultData(resultData),
    .resultReady(resultReady), .notReady(notReady)
  );

  // converter model: ready bit after edge 1, data bits after edges 2..13
  logic [11:0] modelWord = 12'h000;
  logic        modelRdy = 1'b1;
  int          modelEdge = 0;

  always @(posedge adcConv) modelEdge = 0;
  always @(posedge adcSclk) begin
    modelEdge = modelEdge + 1;
    #1;
    if (modelEdge == 1) adcSdout = modelRdy;
    else if (modelEdge >= 2 && modelEdge <= 13) adcSdout = modelWord[13 - modelEdge];
    else adcSdout = 1'b0;
  end

  // line monitors
  int convRises = 0, sclkRises = 0;
  int convRun = 0, sclkRun = 0, lastConvW = 0, lastSclkW = 0;
  int periodCnt = 0, minP = 9999, maxP = 0, leadCnt = 0, lead = 0;
  logic gotRise = 1'b0, prevConv = 1'b0, prevSclk = 1'b0;

  always @(posedge clk) begin
    prevConv  <= adcConv;
    prevSclk  <= adcSclk;
    convRun   <= adcConv ? convRun + 1 : 0;
    sclkRun   <= adcSclk ? sclkRun + 1 : 0;
    leadCnt   <= adcConv ? 0 : leadCnt + 1;
    periodCnt <= (adcSclk && !prevSclk) ? 1 : periodCnt + 1;
    if (prevConv && !adcConv) lastConvW <= convRun;
    if (prevSclk && !adcSclk) lastSclkW <= sclkRun;
    if (adcConv && !prevConv) begin
      convRises <= convRises + 1;
      gotRise <= 1'b0; minP <= 9999; maxP <= 0;
    end
    if (adcSclk && !prevSclk) begin
      sclkRises <= sclkRises + 1;
      if (!gotRise) begin lead <= leadCnt; gotRise <= 1'b1; end
      else begin
        if (periodCnt < minP) minP <= periodCnt;
        if (periodCnt > maxP) maxP <= periodCnt;
      end
    end
  end

  int total = 0, bad = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  int busyCycles, rvAt, rvCount;
  logic [11:0] capData;
  logic capRdy;

  task automatic runCmd(input logic [1:0] op, input int injectAt);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op;
    @(negedge clk);
    cmdValid = 1'b0;
    busyCycles = 0; rvAt = -1; rvCount = 0;
    while (busy && busyCycles < 1000) begin
      if (resultValid) begin
        rvAt = busyCycles; rvCount++; capData = resultData; capRdy = resultReady;
      end
      if (busyCycles == injectAt) begin cmdValid = 1'b1; cmdOp = 2'd2; end
      else cmdValid = 1'b0;
      busyCycles++;
      @(negedge clk);
    end
    cmdValid = 1'b0;
    @(negedge clk);
  endtask

  task automatic testReset();
    check(busy == 1'b0, "R10 busy", busy, 0);
    check(adcConv == 1'b0 && adcSclk == 1'b0, "R10 lines", {adcConv, adcSclk}, 0);
    check(resultValid == 1'b0, "R10 valid", resultValid, 0);
    check(notReady == 1'b0, "R10 notReady", notReady, 0);
  endtask

  task automatic testConvert(input logic [11:0] word, input logic rdy, input logic expNotReady);
    int c0, s0;
    modelWord = word; modelRdy = rdy;
    c0 = convRises; s0 = sclkRises;
    runCmd(2'd0, -1);
    check(capData == word, "R4 data", capData, word);
    check(capRdy == rdy, "R4 ready bit", capRdy, rdy);
    check(rvCount == 1, "R5 single pulse", rvCount, 1);
    check(busyCycles - rvAt == GAP, "R5 gap", busyCycles - rvAt, GAP);
    check(busyCycles == CONV_BUSY, "R1 busy length", busyCycles, CONV_BUSY);
    check(convRises - c0 == 1, "R2 one start", convRises - c0, 1);
    check(lastConvW == CONV_HI, "R2 start width", lastConvW, CONV_HI);
    check(lead == LEAD + DIV_HALF, "R2 lead", lead, LEAD + DIV_HALF);
    check(sclkRises - s0 == 16, "R3 edge count", sclkRises - s0, 16);
    check(lastSclkW == DIV_HALF, "R3 high width", lastSclkW, DIV_HALF);
    check(minP == 2 * DIV_HALF && maxP == 2 * DIV_HALF, "R3 period", maxP, 2 * DIV_HALF);
    check(notReady == expNotReady, "R9 notReady", notReady, expNotReady);
  endtask

  task automatic testPower(input logic [1:0] op, input int pulses);
    int c0, s0, expBusy;
    c0 = convRises; s0 = sclkRises;
    expBusy = 2 * pulses * CONV_HI + GUARD;
    runCmd(op, -1);
    check(convRises - c0 == pulses, (pulses == 2) ? "R6 pulse count" : "R7 pulse count",
          convRises - c0, pulses);
    check(sclkRises - s0 == 0, "R6 clock held low", sclkRises - s0, 0);
    check(lastConvW == CONV_HI, "R6 pulse width", lastConvW, CONV_HI);
    check(busyCycles == expBusy, "R6 busy guard", busyCycles, expBusy);
    if (pulses == 4) check(notReady == 1'b1, "R7 sleep sets notReady", notReady, 1);
  endtask

  task automatic testWake();
    int c0, s0;
    c0 = convRises; s0 = sclkRises;
    runCmd(2'd3, -1);
    check(sclkRises - s0 == 1, "R8 one clock pulse", sclkRises - s0, 1);
    check(convRises - c0 == 0, "R8 no start", convRises - c0, 0);
    check(lastSclkW == DIV_HALF, "R8 pulse width", lastSclkW, DIV_HALF);
    check(busyCycles == DIV_HALF + WAKEW, "R8 busy", busyCycles, DIV_HALF + WAKEW);
  endtask

  task automatic testIgnored();
    int c0;
    modelWord = 12'h3C5; modelRdy = 1'b1;
    c0 = convRises;
    runCmd(2'd0, 5);   // sleep request injected while busy
    check(convRises - c0 == 1, "R1 ignored cmd no pulses", convRises - c0, 1);
    check(notReady == 1'b0, "R1 ignored sleep", notReady, 0);
    check(busyCycles == CONV_BUSY, "R1 ignored busy", busyCycles, CONV_BUSY);
    check(capData == 12'h3C5, "R1 ignored data", capData, 12'h3C5);
  endtask

  logic finished = 1'b0;

  initial begin
    repeat (4) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testReset();
    testConvert(12'hA5C, 1'b1, 1'b0);
    testConvert(12'hFFF, 1'b1, 1'b0);
    testConvert(12'h000, 1'b1, 1'b0);
    testConvert(12'h001, 1'b1, 1'b0);
    testConvert(12'h800, 1'b0, 1'b1);
    testConvert(12'h555, 1'b1, 1'b0);
    testPower(2'd1, 2);
    testWake();
    testPower(2'd2, 4);
    testWake();
    testConvert(12'h123, 1'b0, 1'b1);
    testConvert(12'h456, 1'b1, 1'b0);
    testIgnored();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule